// File: doc/BRIEF.md
# Nibble-Addressed Accumulator Processor

This block is a minimal 8-bit processor. It keeps program and data in one memory of sixteen bytes. Every instruction is one byte. The upper four bits select the operation. The lower four bits name a memory location, which is the only operand.

The processor holds five pieces of state: a program counter, an instruction register, an operand address register, an accumulator and a sequencer state. A small adder/subtractor combines the accumulator with the addressed byte. A zero detector on the accumulator lets a conditional jump copy the instruction's address field straight into the program counter.

Test logic fills the memory through a preload port while reset is held, then releases reset. It watches the halt output and reads results back through the same port's read data.

The sequencer moves through four named states:
- FETCH reads the byte at the program counter into the instruction register and advances the counter.
- DECODE latches the address field into the operand address register.
- EXEC carries out the operation.
- HALTED is the stop state.

Transitions:
- FETCH→DECODE and DECODE→EXEC always happen.
- EXEC→FETCH happens for every opcode except halt.
- EXEC→HALTED happens on halt.
- HALTED→HALTED holds until reset, and reset returns the sequencer to FETCH.

Top module: `nib_cpu`

## Requirements
- R1: While `rst` is high and `load_en` is high, each rising clock edge writes `load_data` into the memory byte at `load_addr`. While `rst` is low, `load_en` has no effect. `load_rdata` always shows the memory byte at `load_addr`, without waiting for a clock edge.
- R2: While `rst` is high, the program counter and accumulator are cleared, the sequencer is in FETCH and `halted` is low. After release, execution starts at address 0 with an accumulator of 0.
- R3: An instruction byte carries its opcode in bits 7:4 and its operand address in bits 3:0. Opcode 0x0 (load) copies memory[addr] into the accumulator. Opcode 0x1 (store) writes the accumulator into memory[addr].
- R4: Opcode 0x2 (add) sets the accumulator to (accumulator + memory[addr]) mod 256.
- R5: Opcode 0x3 (subtract) sets the accumulator to (accumulator − memory[addr]) mod 256.
- R6: Opcode 0x4 (jump) makes addr the address of the next instruction.
- R7: Opcode 0x5 (jump-if-zero) makes addr the next instruction address when the accumulator is 0. Otherwise execution continues at the following address.
- R8: Opcodes 0x6 to 0xE change neither the accumulator nor memory, and execution continues at the following address.
- R9: Each instruction takes exactly three clock cycles (FETCH, DECODE, EXEC). The program counter counts modulo 16, so it wraps from 15 to 0.
- R10: Opcode 0xF (halt) raises `halted` three cycles after its fetch begins. `halted` then stays high, and the program counter and memory stay frozen, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; preload is allowed only while it is high |
| load_en | input | 1 | Preload write enable |
| load_addr | input | 4 | Preload write and read address |
| load_data | input | 8 | Preload write data |
| load_rdata | output | 8 | Memory byte at `load_addr` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench sweeps every accumulator value through the conditional jump. A zero detector that is inverted, or that tests the wrong register, sends nonzero values down the taken path or the zero value down the fall-through path.

It runs 256 operand pairs each through add and subtract, including pairs that carry and borrow past eight bits. A result truncated to the wrong width, or operands swapped in subtraction, shows up in the stored byte.

Further programs cover these cases:
- Every undefined opcode, where a design that decoded one as a load or store would corrupt memory.
- A run that wraps the program counter from 15 to 0, which a counter that saturates would miss.
- Cycle counts per program, which expose an extra or missing sequencer state.
- Preload attempts after reset is released, which must leave memory untouched.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_ADD   = 4'h2,
        OP_SUB   = 4'h3,
        OP_JUMP  = 4'h4,
        OP_JZERO = 4'h5,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALTED = 2'd3
    } seq_state_e;

endpackage

// File: rtl/nib_cpu_mem.sv
module nib_cpu_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_wdata,
    output logic [DW-1:0] pre_rdata,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            if (pre_we) cells[pre_addr] <= pre_wdata;
        end else if (cpu_we) begin
            cells[cpu_addr] <= cpu_wdata;
        end
    end

    assign pre_rdata = cells[pre_addr];
    assign cpu_rdata = cells[cpu_addr];

    // R1
    cpu_write_out_of_reset_chk: assert property (@(posedge clk) cpu_we |-> !rst);
endmodule

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          do_sub,
    output logic [DW-1:0] result,
    output logic          opa_zero
);
    always_comb begin
        if (do_sub) result = opa - opb;
        else        result = opa + opb;
    end

    assign opa_zero = (opa == '0);

    always_comb begin
        if (do_sub) begin
            // R5
            sub_inverse_chk: assert (DW'(result + opb) == opa);
        end else begin
            // R4
            add_inverse_chk: assert (DW'(result - opb) == opa);
        end
    end
endmodule

// File: rtl/nib_cpu_ctrl.sv
module nib_cpu_ctrl
    import nib_cpu_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] alu_a,
    output logic [DW-1:0] alu_b,
    output logic          alu_sub,
    input  logic [DW-1:0] alu_res,
    input  logic          acc_zero,
    output logic          halted
);
    seq_state_e    state, nxt_state;
    logic [AW-1:0] pc;
    logic [AW-1:0] oper_addr;
    logic [DW-1:0] ir;
    logic [DW-1:0] acc;
    opcode_e       op;

    assign op = opcode_e'(ir[DW-1 -: OP_W]);

    // sequencer state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt_state;
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_FETCH:  nxt_state = ST_DECODE;
            ST_DECODE: nxt_state = ST_EXEC;
            ST_EXEC:   nxt_state = (op == OP_HALT) ? ST_HALTED : ST_FETCH;
            ST_HALTED: nxt_state = ST_HALTED;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            acc       <= '0;
            ir        <= '0;
            oper_addr <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir <= mem_rdata;
                    pc <= pc + 1'b1;
                end
                ST_DECODE: oper_addr <= ir[AW-1:0];
                ST_EXEC: begin
                    case (op)
                        OP_LOAD:  acc <= mem_rdata;
                        OP_ADD:   acc <= alu_res;
                        OP_SUB:   acc <= alu_res;
                        OP_JUMP:  pc  <= ir[AW-1:0];
                        OP_JZERO: if (acc_zero) pc <= ir[AW-1:0];
                        default:  ;
                    endcase
                end
                ST_HALTED: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr  = oper_addr;
        mem_we    = 1'b0;
        mem_wdata = acc;
        alu_a     = acc;
        alu_b     = mem_rdata;
        alu_sub   = 1'b0;
        halted    = 1'b0;
        unique case (state)
            ST_FETCH:  mem_addr = pc;
            ST_DECODE: ;
            ST_EXEC: begin
                mem_we  = (op == OP_STORE);
                alu_sub = (op == OP_SUB);
            end
            ST_HALTED: halted = 1'b1;
        endcase
    end

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && state == ST_FETCH));

    // R9
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> (state == ST_DECODE && pc == $past(pc) + 1'b1));

    // R9
    decode_step_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_DECODE |=> state == ST_EXEC);

    // R7
    jzero_take_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && op == OP_JZERO && acc == '0) |=> pc == $past(ir[AW-1:0]));

    // R7
    jzero_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && op == OP_JZERO && acc != '0) |=> $stable(pc));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_HALTED |=> (state == ST_HALTED && $stable(pc) && $stable(acc)));
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
    import nib_cpu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_en,
    input  logic [ADDR_W-1:0]      load_addr,
    input  logic [OP_W+ADDR_W-1:0] load_data,
    output logic [OP_W+ADDR_W-1:0] load_rdata,
    output logic                   halted
);
    localparam int DW = OP_W + ADDR_W;

    logic [ADDR_W-1:0] mem_addr;
    logic [DW-1:0]     mem_rdata, mem_wdata;
    logic              mem_we;
    logic [DW-1:0]     alu_a, alu_b, alu_res;
    logic              alu_sub, acc_zero;

    nib_cpu_mem #(.AW(ADDR_W), .DW(DW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .pre_we    (load_en),
        .pre_addr  (load_addr),
        .pre_wdata (load_data),
        .pre_rdata (load_rdata),
        .cpu_addr  (mem_addr),
        .cpu_we    (mem_we),
        .cpu_wdata (mem_wdata),
        .cpu_rdata (mem_rdata)
    );

    nib_cpu_alu #(.DW(DW)) u_alu (
        .opa      (alu_a),
        .opb      (alu_b),
        .do_sub   (alu_sub),
        .result   (alu_res),
        .opa_zero (acc_zero)
    );

    nib_cpu_ctrl #(.AW(ADDR_W), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_sub   (alu_sub),
        .alu_res   (alu_res),
        .acc_zero  (acc_zero),
        .halted    (halted)
    );
endmodule

// File: tb/nib_cpu_tb.sv
module nib_cpu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] load_rdata;
    logic       halted;

    int tests = 0;
    int fails = 0;
    int total_cycles = 0;
    logic [7:0] img [16];

    always #4 clk = ~clk;

    nib_cpu u_dut (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .load_rdata (load_rdata),
        .halted     (halted)
    );

    always @(posedge clk) begin
        total_cycles++;
        if (total_cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endtask

    task automatic run_img(output int cyc);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = i[3:0];
            load_data = img[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        rst     = 1'b0;
        cyc = 0;
        while (!halted && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        load_addr = a;
        #1;
        v = load_rdata;
    endtask

    initial begin
        int cyc;
        logic [7:0] v, w;

        // R2: reset state
        repeat (3) @(negedge clk);
        chk("R2 halted low in reset", int'(halted), 0);

        // R1: preload readback
        for (int i = 0; i < 16; i++) img[i] = 8'((i * 29) ^ 8'hA5);
        img[0] = 8'hF0;
        run_img(cyc);
        for (int i = 0; i < 16; i++) begin
            peek(i[3:0], v);
            chk("R1 preload readback", int'(v), int'(img[i]));
        end
        // R10/R9: halt at address 0 takes 3 cycles
        chk("R10 halt latency", cyc, 3);
        chk("R10 halted high", int'(halted), 1);
        // R1: preload ignored out of reset
        @(negedge clk);
        load_en = 1'b1; load_addr = 4'h5; load_data = 8'h99;
        repeat (2) @(negedge clk);
        load_en = 1'b0;
        repeat (20) @(negedge clk);
        peek(4'h5, v);
        chk("R1 load ignored out of reset", int'(v), int'(img[5]));
        chk("R10 halted stays high", int'(halted), 1);

        // R2: reset drops halted
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R2 reset clears halted", int'(halted), 0);

        // R2/R3: accumulator 0 after reset, stored by store
        clear_img();
        img[0] = 8'h1F; img[1] = 8'hF0; img[15] = 8'hAB;
        run_img(cyc);
        peek(4'hF, v);
        chk("R2 R3 acc zero after reset", int'(v), 0);
        chk("R9 two instructions", cyc, 6);

        // R4: add sweep
        for (int i = 0; i < 256; i++) begin
            clear_img();
            img[0] = 8'h0E; img[1] = 8'h2F; img[2] = 8'h1D; img[3] = 8'hF0;
            img[14] = 8'(i); img[15] = 8'(i * 37 + 11);
            run_img(cyc);
            peek(4'hD, v);
            chk("R4 add", int'(v), int'(8'(img[14] + img[15])));
            if (i == 0) chk("R9 add program cycles", cyc, 12);
        end

        // R5: subtract sweep
        for (int i = 0; i < 256; i++) begin
            clear_img();
            img[0] = 8'h0E; img[1] = 8'h3F; img[2] = 8'h1D; img[3] = 8'hF0;
            img[14] = 8'(i); img[15] = 8'(i * 53 + 7);
            run_img(cyc);
            peek(4'hD, v);
            chk("R5 sub", int'(v), int'(8'(img[14] - img[15])));
        end

        // R7: jump-if-zero sweep
        for (int i = 0; i < 256; i++) begin
            clear_img();
            img[0] = 8'h0E; img[1] = 8'h54; img[2] = 8'h1D; img[3] = 8'hF0;
            img[4] = 8'h0F; img[5] = 8'h1C; img[6] = 8'hF0;
            img[12] = 8'hEE; img[13] = 8'hEE; img[14] = 8'(i); img[15] = 8'h77;
            run_img(cyc);
            peek(4'hC, v);
            peek(4'hD, w);
            if (i == 0) begin
                chk("R7 taken target", int'(v), 8'h77);
                chk("R7 taken skips store", int'(w), 8'hEE);
                chk("R9 taken cycles", cyc, 15);
            end else begin
                chk("R7 not taken store", int'(w), i);
                chk("R7 not taken skip target", int'(v), 8'hEE);
                if (i == 1) chk("R9 not taken cycles", cyc, 12);
            end
        end

        // R6: unconditional jump
        clear_img();
        img[0] = 8'h45; img[1] = 8'hF0; img[2] = 8'hF0; img[3] = 8'hF0; img[4] = 8'hF0;
        img[5] = 8'h0E; img[6] = 8'h1D; img[7] = 8'hF0; img[14] = 8'h5C;
        run_img(cyc);
        peek(4'hD, v);
        chk("R6 jump", int'(v), 8'h5C);
        chk("R6 jump cycles", cyc, 12);

        // R8: undefined opcodes have no effect
        for (int op = 6; op < 15; op++) begin
            clear_img();
            img[0] = 8'h0E; img[1] = {op[3:0], 4'hC}; img[2] = 8'h1D; img[3] = 8'hF0;
            img[12] = 8'h11; img[14] = 8'h3C;
            run_img(cyc);
            peek(4'hD, v);
            chk("R8 acc unchanged", int'(v), 8'h3C);
            peek(4'hC, v);
            chk("R8 memory unchanged", int'(v), 8'h11);
            chk("R8 cycles", cyc, 12);
        end

        // R9: program counter wraps 15 -> 0
        clear_img();
        img[0] = 8'h5E; img[1] = 8'hF0; img[10] = 8'h33;
        img[14] = 8'h0A; img[15] = 8'h1B;
        run_img(cyc);
        peek(4'hB, v);
        chk("R9 wrap store", int'(v), 8'h33);
        chk("R9 wrap cycles", cyc, 15);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule